// File: doc/BRIEF.md
# Parallel Sub-Block Motion Estimator

This block finds motion vectors for one 16x16 macroblock. The macroblock is divided into sixteen 4x4 sub-blocks, and each sub-block has its own search engine. All sixteen engines run an exhaustive search at the same time over a ±4 pixel window. Each engine keeps the offset with the smallest sum of absolute differences (SAD). When the search ends, a merge step forms larger partitions by grouping neighbouring sub-blocks whose vectors are close to each other.

The host first writes the 256 current-block pixels and the 576 pixels of a 24x24 reference window through two plain write ports. It then pulses `start`. When `done` pulses, the sixteen vectors, their SADs and a partition code are valid. They stay valid until the next search pass.

Top module: `me_parsearch`

## Requirements
- R1: After reset, `busy`, `done`, `part_mode`, `split_mask` and every vector and SAD field read zero.
- R2: A `start` seen while idle raises `busy` on the next cycle. `done` is a one-cycle pulse that appears exactly 1297 cycles after the edge that sampled `start`. This is 81 candidates × 16 pixel cycles plus one merge cycle. `busy` is low in the `done` cycle.
- R3: Pixel addresses are laid out as follows. The current pixel at (row, col) is at `cur_addr` = row*16+col. The reference pixel at window (row, col) is at `ref_addr` = row*24+col, and window row/col 4 lines up with macroblock row/col 0. Sub-block k covers rows 4*(k/4) to 4*(k/4)+3 and columns 4*(k%4) to 4*(k%4)+3. Its vector (dx, dy), each component from -4 to 4, is the offset that gives the smallest SAD over its 16 pixels. The vector is reported as two's complement in `mv_x[4k+3:4k]` and `mv_y[4k+3:4k]`, and the SAD in `sad[12k+11:12k]`.
- R4: When two candidates give the same SAD, the earlier one in raster order is kept. The raster order runs dy from -4 to 4 in the outer loop and dx from -4 to 4 in the inner loop.
- R5: The sixteen sub-blocks are searched on their own. Each can report a different vector, and the result for one does not depend on the pixels of another.
- R6: Two vectors are similar when |dx1-dx2| ≤ 1 and |dy1-dy2| ≤ 1. An 8x8 quadrant q is merged when all six pairs of its four sub-blocks are similar. Quadrant q sits at quadrant row q/2 and quadrant column q%2. Bit q of `split_mask` is 1 when quadrant q stays split.
- R7: `part_mode` is 0 (one 16x16) when all four quadrants merge and the top-left sub-block vectors of the quadrants are pairwise similar. It is 1 (four 8x8) when all quadrants merge but the 16x16 test fails. It is 2 (mixed) otherwise. `split_mask` is zero in modes 0 and 1 and nonzero in mode 2.
- R8: A `start` pulse during a pass is ignored. The pass keeps its timing.
- R9: While the block is idle, the vectors, SADs, `part_mode` and `split_mask` hold their values, even when pixels are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_we | input | 1 | Current-block pixel write enable |
| cur_addr | input | 8 | Current-block pixel address (row*16+col) |
| cur_data | input | 8 | Current-block pixel value |
| ref_we | input | 1 | Reference-window pixel write enable |
| ref_addr | input | 10 | Reference-window address (row*24+col); values ≥ 576 are dropped |
| ref_data | input | 8 | Reference-window pixel value |
| start | input | 1 | Begins a search pass when idle |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse: results valid |
| mv_x | output | 64 | Sixteen 4-bit signed horizontal offsets |
| mv_y | output | 64 | Sixteen 4-bit signed vertical offsets |
| sad | output | 192 | Sixteen 12-bit best SADs |
| part_mode | output | 2 | 0 = 16x16, 1 = four 8x8, 2 = mixed |
| split_mask | output | 4 | Quadrants that stayed split |

## Verification
An all-zero window makes every candidate tie, which separates earliest-candidate selection from any other tie rule. Random windows with a different planted shift for each sub-block show whether the engines are independent and whether the address arithmetic is right. Three shift layouts drive the merge step: near-uniform shifts that should give one 16x16, shifts that are uniform within each quadrant but differ between quadrants, and scattered shifts with one uniform quadrant. Together these separate all three partition codes and the mask bits. A start pulse in the middle of a pass, and pixel writes made while idle, show whether the timing and the held results are left alone.

// File: rtl/me_pkg.sv
package me_pkg;
    localparam int PIX_W    = 8;
    localparam int SUB      = 4;                       // sub-block edge
    localparam int MBW      = 16;                      // macroblock edge
    localparam int SUB_ROW  = MBW / SUB;               // sub-blocks per row
    localparam int NSUB     = SUB_ROW * SUB_ROW;
    localparam int RANGE    = 4;
    localparam int NDIM     = 2 * RANGE + 1;
    localparam int NCAND    = NDIM * NDIM;
    localparam int NPIX     = SUB * SUB;
    localparam int WIN      = MBW + 2 * RANGE;
    localparam int MV_W     = 4;
    localparam int SAD_W    = 12;
    localparam int CAND_W   = $clog2(NCAND);
    localparam int PIXI_W   = $clog2(NPIX);
    localparam int CUR_AW   = $clog2(MBW * MBW);
    localparam int REF_AW   = $clog2(WIN * WIN);
    localparam int NQUAD    = 4;

    typedef logic signed [MV_W-1:0] mv_t;
    typedef enum logic [1:0] {ST_IDLE, ST_SEARCH, ST_MERGE} st_e;
    typedef enum logic [1:0] {PM_WHOLE = 2'd0, PM_QUAD = 2'd1, PM_MIXED = 2'd2} pmode_e;
endpackage

// File: rtl/me_pe.sv
module me_pe
    import me_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             first,
    input  logic             last,
    input  logic             fresh,
    input  logic [PIX_W-1:0] cur_pix,
    input  logic [PIX_W-1:0] ref_pix,
    input  mv_t              cand_x,
    input  mv_t              cand_y,
    output logic [SAD_W-1:0] best_sad,
    output mv_t              best_x,
    output mv_t              best_y
);
    typedef struct packed {
        logic [SAD_W-1:0] acc;
        logic [SAD_W-1:0] best;
        mv_t              bx;
        mv_t              by;
    } pe_s;

    pe_s q, d;
    logic [PIX_W-1:0] diff;
    logic [SAD_W-1:0] total;

    always_comb begin
        d     = q;
        diff  = (cur_pix > ref_pix) ? (cur_pix - ref_pix) : (ref_pix - cur_pix);
        total = first ? SAD_W'(diff) : (q.acc + SAD_W'(diff));
        if (en) begin
            d.acc = total;
            if (last && (fresh || total < q.best)) begin
                d.best = total;
                d.bx   = cand_x;
                d.by   = cand_y;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign best_sad = q.best;
    assign best_x   = q.bx;
    assign best_y   = q.by;
endmodule

// File: rtl/me_merge.sv
module me_merge
    import me_pkg::*;
(
    input  logic [NSUB*MV_W-1:0] mvx,
    input  logic [NSUB*MV_W-1:0] mvy,
    output logic [1:0]           mode,
    output logic [NQUAD-1:0]     split
);
    function automatic int member(input int qd, input int a);
        return ((qd / 2) * 2 + a / 2) * SUB_ROW + (qd % 2) * 2 + (a % 2);
    endfunction

    function automatic logic close(input mv_t ax, input mv_t ay, input mv_t bx, input mv_t by);
        int ddx, ddy;
        ddx = int'(ax) - int'(bx);
        ddy = int'(ay) - int'(by);
        return (ddx >= -1) && (ddx <= 1) && (ddy >= -1) && (ddy <= 1);
    endfunction

    mv_t vx [NSUB];
    mv_t vy [NSUB];
    logic [NQUAD-1:0] qok;
    logic whole;

    always_comb begin
        for (int i = 0; i < NSUB; i++) begin
            vx[i] = mvx[i*MV_W +: MV_W];
            vy[i] = mvy[i*MV_W +: MV_W];
        end
        for (int qd = 0; qd < NQUAD; qd++) begin
            qok[qd] = 1'b1;
            for (int a = 0; a < 4; a++)
                for (int b = a + 1; b < 4; b++)
                    if (!close(vx[member(qd, a)], vy[member(qd, a)],
                               vx[member(qd, b)], vy[member(qd, b)]))
                        qok[qd] = 1'b0;
        end
        whole = &qok;
        for (int a = 0; a < NQUAD; a++)
            for (int b = a + 1; b < NQUAD; b++)
                if (!close(vx[member(a, 0)], vy[member(a, 0)],
                           vx[member(b, 0)], vy[member(b, 0)]))
                    whole = 1'b0;
        if (whole)     mode = PM_WHOLE;
        else if (&qok) mode = PM_QUAD;
        else           mode = PM_MIXED;
        split = ~qok;
    end
endmodule

// File: rtl/me_parsearch.sv
module me_parsearch
    import me_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cur_we,
    input  logic [CUR_AW-1:0]      cur_addr,
    input  logic [PIX_W-1:0]       cur_data,
    input  logic                   ref_we,
    input  logic [REF_AW-1:0]      ref_addr,
    input  logic [PIX_W-1:0]       ref_data,
    input  logic                   start,
    output logic                   busy,
    output logic                   done,
    output logic [NSUB*MV_W-1:0]   mv_x,
    output logic [NSUB*MV_W-1:0]   mv_y,
    output logic [NSUB*SAD_W-1:0]  sad,
    output logic [1:0]             part_mode,
    output logic [NQUAD-1:0]       split_mask
);
    typedef struct packed {
        st_e               st;
        logic [CAND_W-1:0] cand;
        logic [PIXI_W-1:0] pix;
        logic              done;
        logic [1:0]        mode;
        logic [NQUAD-1:0]  split;
    } ctl_s;

    ctl_s q, d;

    logic [PIX_W-1:0] cur_mem [MBW*MBW];
    logic [PIX_W-1:0] ref_mem [WIN*WIN];

    always_ff @(posedge clk) begin
        if (cur_we) cur_mem[cur_addr] <= cur_data;
        if (ref_we && (int'(ref_addr) < WIN * WIN)) ref_mem[ref_addr] <= ref_data;
    end

    logic [CAND_W-1:0] off_x, off_y;
    logic [PIXI_W-1:0] pr, pc;
    mv_t               cand_x, cand_y;
    logic              pe_en, pe_first, pe_last, pe_fresh;
    logic [1:0]        mg_mode;
    logic [NQUAD-1:0]  mg_split;

    always_comb begin
        off_x    = q.cand % CAND_W'(NDIM);
        off_y    = q.cand / CAND_W'(NDIM);
        cand_x   = MV_W'(off_x) - MV_W'(RANGE);
        cand_y   = MV_W'(off_y) - MV_W'(RANGE);
        pr       = q.pix / PIXI_W'(SUB);
        pc       = q.pix % PIXI_W'(SUB);
        pe_en    = (q.st == ST_SEARCH);
        pe_first = (q.pix == '0);
        pe_last  = (q.pix == PIXI_W'(NPIX - 1));
        pe_fresh = (q.cand == '0);
    end

    for (genvar k = 0; k < NSUB; k++) begin : g_pe
        localparam int BY = k / SUB_ROW;
        localparam int BX = k % SUB_ROW;
        logic [CUR_AW-1:0] ci;
        logic [REF_AW-1:0] ri;
        always_comb begin
            ci = CUR_AW'((BY * SUB + int'(pr)) * MBW + BX * SUB + int'(pc));
            ri = REF_AW'((BY * SUB + int'(pr) + int'(off_y)) * WIN
                         + BX * SUB + int'(pc) + int'(off_x));
        end
        me_pe u_pe (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (pe_en),
            .first    (pe_first),
            .last     (pe_last),
            .fresh    (pe_fresh),
            .cur_pix  (cur_mem[ci]),
            .ref_pix  (ref_mem[ri]),
            .cand_x   (cand_x),
            .cand_y   (cand_y),
            .best_sad (sad[k*SAD_W +: SAD_W]),
            .best_x   (mv_x[k*MV_W +: MV_W]),
            .best_y   (mv_y[k*MV_W +: MV_W])
        );
    end

    me_merge u_merge (
        .mvx   (mv_x),
        .mvy   (mv_y),
        .mode  (mg_mode),
        .split (mg_split)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: if (start) begin
                d.st   = ST_SEARCH;
                d.cand = '0;
                d.pix  = '0;
            end
            ST_SEARCH: begin
                d.pix = q.pix + 1'b1;
                if (pe_last) begin
                    d.pix = '0;
                    if (q.cand == CAND_W'(NCAND - 1)) d.st = ST_MERGE;
                    else                              d.cand = q.cand + 1'b1;
                end
            end
            ST_MERGE: begin
                d.st    = ST_IDLE;
                d.done  = 1'b1;
                d.mode  = mg_mode;
                d.split = mg_split;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign busy       = (q.st != ST_IDLE);
    assign done       = q.done;
    assign part_mode  = q.mode;
    assign split_mask = q.split;
endmodule

// File: rtl/me_parsearch_chk.sv
module me_parsearch_chk
    import me_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic                  busy,
    input logic                  done,
    input logic [NSUB*MV_W-1:0]  mv_x,
    input logic [NSUB*MV_W-1:0]  mv_y,
    input logic [NSUB*SAD_W-1:0] sad,
    input logic [1:0]            part_mode,
    input logic [NQUAD-1:0]      split_mask
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                  // R2
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && $past(busy));                                   // R2
    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));                                    // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(mv_x) && $stable(mv_y) && $stable(sad)
                  && $stable(part_mode) && $stable(split_mask));          // R9
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        part_mode != 2'd3);                                               // R7
    AST_MIXED_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (part_mode == 2'd2) |-> (split_mask != '0));                      // R7
    AST_MERGED_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (part_mode != 2'd2) |-> (split_mask == '0));                      // R7

    for (genvar k = 0; k < NSUB; k++) begin : g_rng
        AST_MV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            ($signed(mv_x[k*MV_W +: MV_W]) >= -RANGE) && ($signed(mv_x[k*MV_W +: MV_W]) <= RANGE)
            && ($signed(mv_y[k*MV_W +: MV_W]) >= -RANGE) && ($signed(mv_y[k*MV_W +: MV_W]) <= RANGE)); // R3
    end
endmodule

bind me_parsearch me_parsearch_chk u_chk (.*);

// File: tb/me_parsearch_tb.sv
`timescale 1ns/1ps
module me_parsearch_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cur_we = 1'b0;
    logic [7:0]   cur_addr = '0;
    logic [7:0]   cur_data = '0;
    logic         ref_we = 1'b0;
    logic [9:0]   ref_addr = '0;
    logic [7:0]   ref_data = '0;
    logic         start = 1'b0;
    logic         busy, done;
    logic [63:0]  mv_x, mv_y;
    logic [191:0] sad;
    logic [1:0]   part_mode;
    logic [3:0]   split_mask;

    always #2 clk = ~clk;

    me_parsearch u_dut (.*);

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    int curm [256];
    int refm [576];
    int sx [16];
    int sy [16];
    int ex [16];
    int ey [16];
    int es [16];
    int emode, emask;
    int lfsr = 12345;

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int nextr();
        lfsr = (lfsr * 1103515245 + 12345) & 32'h7fffffff;
        return (lfsr >> 8) & 255;
    endfunction

    function automatic bit near(input int a, input int b);
        int dx, dy;
        dx = ex[a] - ex[b];
        dy = ey[a] - ey[b];
        return (dx >= -1 && dx <= 1 && dy >= -1 && dy <= 1);
    endfunction

    // exhaustive search and partition decision, behavioural
    task automatic model();
        bit qm [4];
        bit all4, one;
        int tl [4];
        for (int k = 0; k < 16; k++) begin
            int by = (k / 4) * 4;
            int bx = (k % 4) * 4;
            es[k] = -1;
            for (int dy = -4; dy <= 4; dy++)
                for (int dx = -4; dx <= 4; dx++) begin
                    int s = 0;
                    for (int r = 0; r < 4; r++)
                        for (int c = 0; c < 4; c++) begin
                            int a = curm[(by + r) * 16 + bx + c];
                            int b = refm[(by + r + dy + 4) * 24 + bx + c + dx + 4];
                            s += (a > b) ? a - b : b - a;
                        end
                    if (es[k] < 0 || s < es[k]) begin
                        es[k] = s; ex[k] = dx; ey[k] = dy;
                    end
                end
        end
        all4 = 1;
        emask = 0;
        for (int qd = 0; qd < 4; qd++) begin
            int m [4];
            int base = (qd / 2) * 8 + (qd % 2) * 2;
            m[0] = base; m[1] = base + 1; m[2] = base + 4; m[3] = base + 5;
            tl[qd] = base;
            qm[qd] = 1;
            for (int a = 0; a < 4; a++)
                for (int b = a + 1; b < 4; b++)
                    if (!near(m[a], m[b])) qm[qd] = 0;
            if (!qm[qd]) begin all4 = 0; emask |= (1 << qd); end
        end
        one = all4;
        for (int a = 0; a < 4; a++)
            for (int b = a + 1; b < 4; b++)
                if (!near(tl[a], tl[b])) one = 0;
        emode = one ? 0 : (all4 ? 1 : 2);
    endtask

    task automatic build(input int pat);
        for (int i = 0; i < 576; i++) refm[i] = (pat == 0) ? 0 : nextr();
        for (int k = 0; k < 16; k++) begin
            int qd = (k / 8) * 2 + (k % 4) / 2;
            case (pat)
                1: begin sx[k] = 1 + (k % 2); sy[k] = -1; end
                2: begin
                    sx[k] = (qd == 0) ? -3 : (qd == 1) ? 3 : (qd == 2) ? 0 : -3;
                    sy[k] = (qd == 0) ? -3 : (qd == 1) ? 3 : (qd == 2) ? 2 : 3;
                end
                3: begin
                    sx[k] = (qd == 3) ? 2 : ((k * 7) % 9) - 4;
                    sy[k] = (qd == 3) ? -2 : ((k * 4) % 9) - 4;
                end
                default: begin sx[k] = (k % 9) - 4; sy[k] = ((k * 5 + 3) % 9) - 4; end
            endcase
            for (int r = 0; r < 4; r++)
                for (int c = 0; c < 4; c++) begin
                    int y = (k / 4) * 4 + r;
                    int x = (k % 4) * 4 + c;
                    curm[y * 16 + x] = refm[(y + sy[k] + 4) * 24 + x + sx[k] + 4];
                end
        end
    endtask

    task automatic load();
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            cur_we = 1; cur_addr = 8'(i); cur_data = 8'(curm[i]);
        end
        @(negedge clk); cur_we = 0;
        for (int i = 0; i < 576; i++) begin
            @(negedge clk);
            ref_we = 1; ref_addr = 10'(i); ref_data = 8'(refm[i]);
        end
        @(negedge clk); ref_we = 0;
        // out-of-range reference write is dropped
        ref_we = 1; ref_addr = 10'd600; ref_data = 8'hAA;
        @(negedge clk); ref_we = 0;
    endtask

    task automatic compare_results(input string tag);
        for (int k = 0; k < 16; k++) begin
            check({tag, " R3 mv_x"}, int'($signed(mv_x[k*4 +: 4])), ex[k]);
            check({tag, " R3 mv_y"}, int'($signed(mv_y[k*4 +: 4])), ey[k]);
            check({tag, " R3 R5 sad"}, int'(sad[k*12 +: 12]), es[k]);
        end
        check({tag, " R6 R7 part_mode"}, int'(part_mode), emode);
        check({tag, " R6 split_mask"}, int'(split_mask), emask);
    endtask

    // cycle model of busy/done
    bit mbusy = 0, mdone = 0;
    int mcnt = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            mbusy = 0; mdone = 0; mcnt = 0;
        end else begin
            mdone = 0;
            if (mbusy) begin
                mcnt++;
                if (mcnt == 1297) begin mbusy = 0; mdone = 1; end
            end else if (start) begin
                mbusy = 1; mcnt = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R2 R8 busy", int'(busy), int'(mbusy));
            check("R2 done", int'(done), int'(mdone));
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            mismatched++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 mv_x", int'(mv_x != 0), 0);
        check("R1 mv_y", int'(mv_y != 0), 0);
        check("R1 sad", int'(sad != 0), 0);
        check("R1 part_mode", int'(part_mode), 0);
        check("R1 split_mask", int'(split_mask), 0);
        rst_n = 1;
        for (int p = 0; p < 5; p++) begin
            build(p);
            load();
            if (p > 0) compare_results("R9 held");
            model();
            @(negedge clk); start = 1;
            @(negedge clk); start = 0;
            if (p == 4) begin
                repeat (100) @(negedge clk);
                start = 1;                       // R8 mid-pass start
                @(negedge clk); start = 0;
            end
            while (!done && !finished) @(negedge clk);
            if (p == 0) compare_results("R4 ties");
            else        compare_results("R5 pattern");
            @(negedge clk);
        end
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule